// File: doc/BRIEF.md
# Strap-Configured Host Bus Target

This block lets an external host processor read and write a small bank of 16-bit registers inside a switch device over a synchronous address/data bus. A bus cycle opens when the host pulls the address strobe and chip select low together. The block then answers with an active-low ready. A read drives data on the bus only while that data is valid. A write takes the data in the bus period in which ready is low. A single interrupt line with programmable polarity signals a sticky event to the host.

The host interface has no valid/ready handshake of its own. The bus handshake takes its place: the host holds the strobe and its data until it sees ready low, and the target holds off completion only by the cycle counts given below. All pins are plain control or data signals.

Five strap inputs fix the protocol details. The block samples them on the first clock edge after reset is released and ignores them from then on, so the host may reuse those pins as data. The straps select the clock ratio, the byte order, the polarity of the read/write control, the reported bus width and the ready-to-data timing.

Top module: `hbus_strap_slave`

## Requirements
- R1: The block takes `strap_i` on the first rising clock edge after `rst_n` is released. Any later change on `strap_i` has no effect until the next reset.
- R2: Strap bit 0 sets the clock ratio. With 0, the bus logic advances on every clock. With 1, it advances on every second clock, so ready stays low for exactly 2 clocks and a strobe is answered within 2 clocks.
- R3: Strap bit 1 sets the byte order. With 0, data passes unchanged. With 1, the two bytes of each word are swapped on writes and on reads: a host write of 0x0300 stores 0x0003, and a stored 0x0001 reads as 0x0100.
- R4: Strap bit 2 sets the read/write control polarity. With 0, `rwc_i` high means read. With 1, `rwc_i` high means write.
- R5: Strap bit 3 set to 1 selects 32-bit host width. In that mode `bs16_n_o` is low in every clock in which ready is low, so the host splits its access into 16-bit transfers. With 0, `bs16_n_o` stays high.
- R6: Strap bit 4 set to 1 makes read data valid, with `data_oe_o` high, in the same bus period as ready low. With 0, ready is low for one bus period and the data follow in the next period, with ready released.
- R7: A cycle starts on a bus tick that sees `ads_n_i` and `cs_n_i` both low, and ready goes low in the next bus period. With `cs_n_i` high, the strobe is ignored: ready stays high and no register changes.
- R8: Word addresses 0 to 15 are mapped. Addresses 2 to 15 read back what was last written to them. An address with any bit above bit 3 set reads 0, and a write to it changes no register.
- R9: Register 0 is the configuration register. Bit 0 = 1 makes the interrupt active high, and 0 makes it active low. Bit 1 enables the interrupt. `int_o` is at its active level exactly when the enable is set and the status bit is set.
- R10: Register 1 bit 0 is a status bit, set in any clock with `event_i` high. Writing 1 to that bit clears it and writing 0 leaves it. When both happen in the same clock, the event wins.
- R11: After reset, `rdy_n_o` and `bs16_n_o` are high, `data_oe_o` is low, `data_o` is 0, all registers are 0 and `int_o` is high (inactive, active-low polarity).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host bus clock (1X or 2X) |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 5 | Configuration straps, sampled at the end of reset |
| addr_i | input | 11 | Word address from the host |
| data_i | input | 16 | Write data from the host |
| data_o | output | 16 | Read data to the host, zero when not enabled |
| data_oe_o | output | 1 | Read data output enable |
| ads_n_i | input | 1 | Address strobe, active low |
| cs_n_i | input | 1 | Chip select, active low |
| rwc_i | input | 1 | Read/write control, polarity set by strap |
| rdy_n_o | output | 1 | Ready, driven low only on completion |
| bs16_n_o | output | 1 | Bus-size-16 response, active low |
| int_o | output | 1 | Interrupt with programmable polarity |
| event_i | input | 1 | Event that sets the interrupt status bit |

## Verification
Ready is due one bus period after the tick that sees the strobe: within 1 clock at the 1X ratio and within 2 clocks at the 2X ratio. It then stays low for exactly one bus period. The bench drives inputs on falling edges, polls `rdy_n_o` on falling edges with a bounded count and checks that the count fits the ratio. It then steps whole bus periods to check the data phase: in the same period for same-period timing, and one period later for early timing. An interrupt effect is due at the falling edge right after the clock that saw `event_i` or the completed write, and the bench checks `int_o` there.

// File: rtl/hbus_pkg.sv
`timescale 1ns/1ps
package hbus_pkg;
  localparam int HB_DATA_W = 16;

  // bit order matches strap_i[4:0]
  typedef struct packed {
    logic rdy_same;  // [4] data valid with ready
    logic width32;   // [3] 32-bit host
    logic wr_high;   // [2] rwc high = write
    logic big_end;   // [1] byte swap
    logic clk2x;     // [0] 2X clock
  } strap_t;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WR       = 2'd1,
    ST_RD_EARLY = 2'd2,
    ST_RD_DATA  = 2'd3
  } bus_st_t;

  function automatic logic [HB_DATA_W-1:0] swap_bytes(input logic [HB_DATA_W-1:0] d);
    logic [HB_DATA_W-1:0] r;
    for (int b = 0; b < HB_DATA_W/8; b++)
      r[b*8 +: 8] = d[(HB_DATA_W/8-1-b)*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/hbus_strap_cfg.sv
`timescale 1ns/1ps
module hbus_strap_cfg
  import hbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic [4:0] strap_i,
  output strap_t cfg_o,
  output logic   tick_o
);
  logic   run_q;
  logic   ph_q;
  strap_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ph_q  <= 1'b0;
      cfg_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (!run_q) cfg_q <= strap_t'(strap_i);
      if (run_q)  ph_q  <= ~ph_q;
    end
  end

  assign cfg_o  = cfg_q;
  assign tick_o = run_q && (!cfg_q.clk2x || ph_q);

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> $stable(cfg_q));
endmodule

// File: rtl/hbus_cycle_fsm.sv
`timescale 1ns/1ps
module hbus_cycle_fsm
  import hbus_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_high_i,
  input  logic              rdy_same_i,
  input  logic              ads_n_i,
  input  logic              cs_n_i,
  input  logic              rwc_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic              oe_o,
  output logic              rdy_n_o
);
  bus_st_t           st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              is_read;

  assign is_read = wr_high_i ? !rwc_i : rwc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
    end else if (tick_i) begin
      unique case (st_q)
        ST_IDLE: if (!ads_n_i && !cs_n_i) begin
          addr_q <= addr_i;
          if (is_read) st_q <= rdy_same_i ? ST_RD_DATA : ST_RD_EARLY;
          else         st_q <= ST_WR;
        end
        ST_WR:       st_q <= ST_IDLE;
        ST_RD_EARLY: st_q <= ST_RD_DATA;
        ST_RD_DATA:  st_q <= ST_IDLE;
        default:     st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rdy_n_o = 1'b1;
    unique case (st_q)
      ST_WR, ST_RD_EARLY: rdy_n_o = 1'b0;
      ST_RD_DATA:         rdy_n_o = !rdy_same_i;
      default:            rdy_n_o = 1'b1;
    endcase
  end

  assign oe_o    = (st_q == ST_RD_DATA);
  assign wr_en_o = tick_i && (st_q == ST_WR);
  assign addr_o  = addr_q;

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && cs_n_i) |=> (st_q == ST_IDLE));
  // R6
  early_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(oe_o) && !rdy_same_i) |-> ($past(rdy_n_o) == 1'b0));
  // R6
  same_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && rdy_same_i) |-> !rdy_n_o);
endmodule

// File: rtl/hbus_regfile.sv
`timescale 1ns/1ps
module hbus_regfile #(
  parameter int NREGS  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              event_i,
  output logic              irq_o
);
  localparam int IDX_W = $clog2(NREGS);

  logic [NREGS-1:0][DATA_W-1:0] words;
  logic                         mapped;
  logic [IDX_W-1:0]             idx;
  logic                         irq_act;

  assign mapped = (addr_i[ADDR_W-1:IDX_W] == '0);
  assign idx    = addr_i[IDX_W-1:0];

  for (genvar i = 0; i < NREGS; i++) begin : g_word
    logic hit;
    assign hit = wr_en_i && mapped && (idx == IDX_W'(i));
    if (i == 1) begin : g_status
      logic stat_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    stat_q <= 1'b0;
        else if (event_i)              stat_q <= 1'b1;
        else if (hit && wdata_i[0])    stat_q <= 1'b0;
      end
      assign words[i] = {{(DATA_W-1){1'b0}}, stat_q};
    end else begin : g_plain
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wdata_i;
      end
      assign words[i] = q;
    end
  end

  assign rdata_o = mapped ? words[idx] : '0;
  assign irq_act = words[0][1] && words[1][0];
  assign irq_o   = words[0][0] ? irq_act : !irq_act;

  // R10
  stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_i |=> words[1][0]);
  // R10
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(1) && wdata_i[0] && !event_i) |=> !words[1][0]);
  // R8
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !mapped && !event_i) |=> $stable(words));
endmodule

// File: rtl/hbus_strap_slave.sv
`timescale 1ns/1ps
module hbus_strap_slave
  import hbus_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int NREGS  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [4:0]           strap_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [HB_DATA_W-1:0] data_i,
  output logic [HB_DATA_W-1:0] data_o,
  output logic                 data_oe_o,
  input  logic                 ads_n_i,
  input  logic                 cs_n_i,
  input  logic                 rwc_i,
  output logic                 rdy_n_o,
  output logic                 bs16_n_o,
  output logic                 int_o,
  input  logic                 event_i
);
  strap_t                cfg;
  logic                  tick;
  logic [ADDR_W-1:0]     acc_addr;
  logic                  wr_en;
  logic                  oe;
  logic                  rdy_n;
  logic [HB_DATA_W-1:0]  rdata;
  logic [HB_DATA_W-1:0]  wdata;

  hbus_strap_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .cfg_o(cfg), .tick_o(tick)
  );

  hbus_cycle_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .wr_high_i(cfg.wr_high), .rdy_same_i(cfg.rdy_same),
    .ads_n_i(ads_n_i), .cs_n_i(cs_n_i), .rwc_i(rwc_i), .addr_i(addr_i),
    .addr_o(acc_addr), .wr_en_o(wr_en), .oe_o(oe), .rdy_n_o(rdy_n)
  );

  assign wdata = cfg.big_end ? swap_bytes(data_i) : data_i;

  hbus_regfile #(.NREGS(NREGS), .DATA_W(HB_DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(acc_addr),
    .wdata_i(wdata), .rdata_o(rdata), .event_i(event_i), .irq_o(int_o)
  );

  assign data_oe_o = oe;
  assign data_o    = oe ? (cfg.big_end ? swap_bytes(rdata) : rdata) : '0;
  assign rdy_n_o   = rdy_n;
  assign bs16_n_o  = !(cfg.width32 && !rdy_n);

  // R5
  bs16_with_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bs16_n_o |-> !rdy_n_o);
  // R2
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.clk2x && tick) |=> !tick);
endmodule

// File: tb/hbus_strap_slave_bench.sv
`timescale 1ns/1ps
module hbus_strap_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  strap = '0;
  logic [10:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        oe, rdy_n, bs16_n, irq;
  logic        ads_n = 1'b1, cs_n = 1'b1, rwc = 1'b0, evt = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic cur_x2, cur_be, cur_wrpol, cur_w32, cur_same;
  int ratio;

  always #5 clk = ~clk;

  hbus_strap_slave u_hbus_strap_slave (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .addr_i(addr), .data_i(din),
    .data_o(dout), .data_oe_o(oe), .ads_n_i(ads_n), .cs_n_i(cs_n), .rwc_i(rwc),
    .rdy_n_o(rdy_n), .bs16_n_o(bs16_n), .int_o(irq), .event_i(evt)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [4:0] s);
    @(negedge clk);
    rst_n = 1'b0; strap = s; ads_n = 1'b1; cs_n = 1'b1; evt = 1'b0;
    {cur_same, cur_w32, cur_wrpol, cur_be, cur_x2} = s;
    ratio = cur_x2 ? 2 : 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    strap = ~s;  // pins now carry unrelated data
    @(negedge clk);
  endtask

  task automatic start_cycle(input logic [10:0] a, input logic rd, input string tag);
    int n = 0;
    addr = a; rwc = rd ? !cur_wrpol : cur_wrpol; ads_n = 1'b0; cs_n = 1'b0;
    do begin @(negedge clk); n++; end while (rdy_n && n < 8);
    chk(tag, "ready latency ok", int'(n <= ratio), 1);
    chk(tag, "bs16 with ready", bs16_n, !cur_w32);
    ads_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic bus_write(input logic [10:0] a, input logic [15:0] d, input string tag);
    int k = 1;
    din = d;
    start_cycle(a, 1'b0, tag);
    @(negedge clk);
    while (rdy_n == 1'b0 && k < 8) begin k++; @(negedge clk); end
    chk(tag, "ready low clocks", k, ratio);
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [10:0] a, input logic [15:0] exp, input string tag);
    start_cycle(a, 1'b1, tag);
    if (cur_same) begin
      chk(tag, "oe with ready", oe, 1);
      chk(tag, "read data", dout, exp);
    end else begin
      chk(tag, "oe low in early ready", oe, 0);
      repeat (ratio) @(negedge clk);
      chk(tag, "oe after early ready", oe, 1);
      chk(tag, "ready released in data phase", rdy_n, 1);
      chk(tag, "read data", dout, exp);
    end
    repeat (ratio) @(negedge clk);
    chk(tag, "bus released", {rdy_n, oe}, 2'b10);
    @(negedge clk);
  endtask

  task automatic pulse_event();
    evt = 1'b1; @(negedge clk); evt = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(5'b10000);
    chk("R11", "ready/oe/bs16", {rdy_n, oe, bs16_n}, 3'b101);
    chk("R11", "int idle level", irq, 1);
    chk("R11", "data_o", dout, 0);
    bus_read(11'd9, 16'h0000, "R11");
  endtask

  task automatic t_regfile();
    do_reset(5'b10000);
    bus_write(11'd2, 16'hA5A5, "R8");
    bus_write(11'd15, 16'h1357, "R8");
    bus_write(11'd4, 16'h1111, "R8");
    bus_read(11'd2, 16'hA5A5, "R8");
    bus_read(11'd15, 16'h1357, "R8");
    bus_write(11'h010, 16'h0003, "R8");
    bus_read(11'd0, 16'h0000, "R8");
    bus_read(11'h010, 16'h0000, "R8");
    chk("R8", "int after unmapped write", irq, 1);
  endtask

  task automatic t_cs_ignore();
    int bad = 0;
    addr = 11'd4; din = 16'hBEEF; rwc = cur_wrpol; ads_n = 1'b0; cs_n = 1'b1;
    repeat (4) begin @(negedge clk); if (!rdy_n) bad++; end
    ads_n = 1'b1;
    chk("R7", "ready low with cs high", bad, 0);
    @(negedge clk);
    bus_read(11'd4, 16'h1111, "R7");
  endtask

  task automatic t_irq();
    do_reset(5'b10000);
    bus_write(11'd0, 16'h0002, "R9");
    chk("R9", "enabled, no event", irq, 1);
    pulse_event();
    chk("R9", "active low asserted", irq, 0);
    bus_read(11'd1, 16'h0001, "R10");
    bus_write(11'd1, 16'h0000, "R10");
    chk("R10", "write 0 keeps status", irq, 0);
    bus_write(11'd1, 16'h0001, "R10");
    chk("R10", "write 1 clears status", irq, 1);
    bus_write(11'd0, 16'h0003, "R9");
    chk("R9", "active high idle", irq, 0);
    pulse_event();
    chk("R9", "active high asserted", irq, 1);
  endtask

  task automatic t_early_and_strap_hold();
    do_reset(5'b00000);  // straps then driven to all ones
    bus_read(11'd0, 16'h0000, "R1");
    bus_write(11'd6, 16'hA5C3, "R6");
    bus_read(11'd6, 16'hA5C3, "R6");
  endtask

  task automatic t_clk2x();
    do_reset(5'b10001);
    bus_write(11'd3, 16'h2468, "R2");
    bus_read(11'd3, 16'h2468, "R2");
  endtask

  task automatic t_big_endian();
    do_reset(5'b10010);
    bus_write(11'd0, 16'h0300, "R3");
    chk("R3", "swapped config, active high idle", irq, 0);
    bus_write(11'd7, 16'h1234, "R3");
    bus_read(11'd7, 16'h1234, "R3");
    pulse_event();
    bus_read(11'd1, 16'h0100, "R3");
  endtask

  task automatic t_rw_polarity();
    do_reset(5'b10100);
    bus_write(11'd8, 16'h5A5A, "R4");
    bus_read(11'd8, 16'h5A5A, "R4");
  endtask

  task automatic t_width32();
    do_reset(5'b11000);
    bus_write(11'd10, 16'hC0DE, "R5");
    bus_read(11'd10, 16'hC0DE, "R5");
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: act=%0h exp=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_regfile();
    t_cs_ignore();
    t_irq();
    t_early_and_strap_hold();
    t_clk2x();
    t_big_endian();
    t_rw_polarity();
    t_width32();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule